// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block decides which of twelve analog inputs an external converter samples next. The inputs form three groups of four. Software loads a 2-bit mode, a 4-bit channel field and a repeat flag, then pulses start. The block then issues one convert request at a time and presents the channel index alongside it. When the converter answers with a done pulse and a 10-bit result, the block stores that result in a per-channel register and moves on. Any channel's register can be read through a combinational read port.

Mode 00 converts one channel, the one named by the channel field. Mode 01 scans one group of four, picked by the upper two bits of the channel field. Mode 10 scans channels 0 to 7. Mode 11 scans channels 0 to 11. With the repeat flag clear, a scan visits each channel of its span once, in ascending order. Start then drops by itself and a completion flag is raised. With the repeat flag set, the scan wraps to the first channel of its span and keeps going until software clears start. Configuration must be written at least one cycle before start is pulsed. While start is high, configuration writes have no effect.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset `busy`, `scan_done` and `conv_req` are 0 and every result register reads 0.
- R2: Mode 00 issues exactly one request, for the channel in `cfg_chan`. Codes 12 to 15 select channel 11. Start then clears and `scan_done` sets, whatever the repeat flag.
- R3: Mode 01 scans the four channels of one group in ascending order. The group comes from `cfg_chan[3:2]`: 00 gives channels 0-3, 01 gives 4-7, and both 10 and 11 give 8-11.
- R4: Mode 10 scans channels 0 to 7 in ascending order.
- R5: Mode 11 scans channels 0 to 11 in ascending order.
- R6: With `cfg_cont`=0, each channel of the span is requested once. After the done pulse of the highest channel, `busy` drops to 0 and `scan_done` rises to 1. `scan_done` clears on the next accepted start.
- R7: With `cfg_cont`=1 in a scan mode, the channel after the last one of the span is the first one of the span. The scan repeats until `start_clr` is pulsed.
- R8: A `cfg_we` write while `busy` is 1 changes neither the mode, the channel field nor the repeat flag.
- R9: A `start_set` pulse at idle makes `conv_req` high in the next cycle. `conv_req` is a one-cycle pulse. No new request is issued until the done pulse of the current one has arrived.
- R10: Each accepted result is stored in the register of the requested channel and reads back on `rd_data` when `rd_chan` names that channel.
- R11: When `start_clr` is pulsed during a conversion, `busy` drops at once. The result of the in-flight conversion is discarded, no further request is issued, and `scan_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode: 00 single, 01 group, 10 eight, 11 twelve |
| cfg_chan | input | 4 | Channel or group select |
| cfg_cont | input | 1 | Repeat flag |
| start_set | input | 1 | Start pulse |
| start_clr | input | 1 | Stop pulse |
| busy | output | 1 | Start bit |
| scan_done | output | 1 | One-shot scan completed |
| conv_req | output | 1 | Convert request pulse |
| conv_chan | output | 4 | Channel to convert |
| conv_done | input | 1 | Conversion done pulse |
| conv_data | input | 10 | Conversion result |
| rd_chan | input | 4 | Result read index |
| rd_data | output | 10 | Stored result of `rd_chan` |

## Verification
The bench goes after the group select where codes 10 and 11 both map to the top group, and after single-mode codes above 11. A design that decoded these naively would request a channel that does not exist. It checks that the repeat flag wraps to the start of the span rather than to channel 0, which a wrong design would break in group 1 or 2. It writes new configuration in the middle of a scan, and then restarts without rewriting it. It stops a repeating scan while a conversion is in flight. The result of that conversion must not overwrite the stored value, and no request may follow the stop.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int RES_W = 10,
  parameter int NCH   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [3:0]       cfg_chan,
  input  logic             cfg_cont,
  input  logic             start_set,
  input  logic             start_clr,
  output logic             busy,
  output logic             scan_done,
  output logic             conv_req,
  output logic [3:0]       conv_chan,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic [3:0]       rd_chan,
  output logic [RES_W-1:0] rd_data
);
  localparam logic [3:0] TOPC = 4'(NCH - 1);
  localparam logic [1:0] TOPG = 2'(NCH / 4 - 1);

  logic [1:0]       mode_q;
  logic [3:0]       chan_q, cur_q, first, last;
  logic             cont_q, start_q, wait_q, req_q, done_q;
  logic [1:0]       grp;
  logic [RES_W-1:0] res_q [NCH];

  assign grp = (chan_q[3:2] > TOPG) ? TOPG : chan_q[3:2];

  always_comb begin
    case (mode_q)
      2'b00:   begin first = (chan_q > TOPC) ? TOPC : chan_q; last = first; end
      2'b01:   begin first = {grp, 2'b00}; last = {grp, 2'b11}; end
      2'b10:   begin first = 4'd0; last = 4'd7; end
      default: begin first = 4'd0; last = TOPC; end
    endcase
  end

  wire take = wait_q && conv_done && !req_q;
  wire live = start_q && !start_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; chan_q <= '0; cont_q <= 1'b0;
      start_q <= 1'b0; wait_q <= 1'b0; req_q <= 1'b0; done_q <= 1'b0;
      cur_q <= '0;
      for (int i = 0; i < NCH; i++) res_q[i] <= '0;
    end else begin
      req_q <= 1'b0;
      if (cfg_we && !start_q) begin
        mode_q <= cfg_mode; chan_q <= cfg_chan; cont_q <= cfg_cont;
      end
      if (start_clr) start_q <= 1'b0;
      if (start_set && !start_q && !wait_q && !start_clr) begin
        start_q <= 1'b1; done_q <= 1'b0; cur_q <= first;
        req_q <= 1'b1; wait_q <= 1'b1;
      end
      if (take) begin
        if (!live) wait_q <= 1'b0;
        else begin
          res_q[cur_q] <= conv_data;
          if (cur_q == last) begin
            if (cont_q && mode_q != 2'b00) begin
              cur_q <= first; req_q <= 1'b1;
            end else begin
              start_q <= 1'b0; done_q <= 1'b1; wait_q <= 1'b0;
            end
          end else begin
            cur_q <= cur_q + 4'd1; req_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy      = start_q;
  assign scan_done = done_q;
  assign conv_req  = req_q;
  assign conv_chan = cur_q;
  assign rd_data   = (rd_chan <= TOPC) ? res_q[rd_chan] : '0;

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mode_q) && $stable(chan_q) && $stable(cont_q)));
  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);
  assert_req_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> busy);
  assert_chan_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (conv_chan <= TOPC));
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_done) |-> !busy);
  assert_stop_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_clr && !start_set) |=> !conv_req);
endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_cont = 0, start_set = 0, start_clr = 0, conv_done = 0;
  logic [1:0] cfg_mode = 0;
  logic [3:0] cfg_chan = 0, rd_chan = 0;
  logic [9:0] conv_data = 0;
  logic busy, scan_done, conv_req;
  logic [3:0] conv_chan;
  logic [9:0] rd_data;

  int errors = 0, checks = 0;
  int req_log [0:127];
  int req_cnt = 0, cd = 0, cur_ch = 0;
  bit abort_pend = 0;
  logic [9:0] exp_mem [0:11];

  always #10 clk = ~clk;

  adc_scan_seq u_dut (.clk, .rst_n, .cfg_we, .cfg_mode, .cfg_chan, .cfg_cont,
    .start_set, .start_clr, .busy, .scan_done, .conv_req, .conv_chan,
    .conv_done, .conv_data, .rd_chan, .rd_data);

  always @(negedge clk) begin
    conv_done = 0;
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin
        conv_done = 1;
        conv_data = 10'($urandom);
        if (!abort_pend) exp_mem[cur_ch] = conv_data;
        abort_pend = 0;
      end
    end
    if (conv_req) begin
      if (req_cnt < 128) req_log[req_cnt] = int'(conv_chan);
      req_cnt++; cur_ch = int'(conv_chan); cd = 3;
    end
  end

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int fst(int m, int c);
    case (m)
      0: return c > 11 ? 11 : c;
      1: return ((c >> 2) == 3 ? 2 : (c >> 2)) * 4;
      default: return 0;
    endcase
  endfunction

  function automatic int lst(int m, int c);
    case (m)
      0: return fst(m, c);
      1: return fst(m, c) + 3;
      2: return 7;
      default: return 11;
    endcase
  endfunction

  function automatic string tag(int m);
    case (m)
      0: return "R2"; 1: return "R3"; 2: return "R4"; default: return "R5";
    endcase
  endfunction

  task automatic cfg(int m, int c, bit ct);
    @(negedge clk); cfg_we = 1; cfg_mode = 2'(m); cfg_chan = 4'(c); cfg_cont = ct;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_set = 1;
    @(negedge clk); start_set = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
  endtask

  task automatic check_seq(int m, int c, string r);
    int f = fst(m, c), l = lst(m, c);
    chk(req_cnt == l - f + 1, r, req_cnt, l - f + 1);
    for (int i = 0; i < l - f + 1 && i < req_cnt; i++)
      if (req_log[i] != f + i) chk(0, r, req_log[i], f + i);
    chk(scan_done == 1 && busy == 0, "R6", {scan_done, busy}, 2);
  endtask

  task automatic run_once(int m, int c, bit ct);
    cfg(m, c, ct);
    req_cnt = 0;
    pulse_start();
    wait_idle();
    check_seq(m, c, tag(m));
  endtask

  task automatic read_all(string r);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); rd_chan = 4'(i); #1;
      chk(rd_data == exp_mem[i], r, rd_data, exp_mem[i]);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 12; i++) exp_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && scan_done == 0 && conv_req == 0, "R1", {busy, scan_done, conv_req}, 0);
    read_all("R1");

    // R9: request in the cycle after the start pulse
    cfg(3, 0, 0);
    req_cnt = 0;
    @(negedge clk); start_set = 1;
    @(negedge clk); start_set = 0;
    chk(conv_req == 1, "R9", conv_req, 1);
    chk(conv_chan == 0, "R9", conv_chan, 0);
    // R8: config write during the scan is ignored
    cfg(1, 8, 1);
    wait_idle();
    check_seq(3, 0, "R8");
    req_cnt = 0;
    pulse_start();
    chk(scan_done == 0, "R6", scan_done, 0);
    wait_idle();
    check_seq(3, 0, "R8");

    // Directed corner cases
    run_once(0, 14, 1);   // R2 code above 11 -> channel 11, repeat flag ignored
    run_once(0, 5, 0);    // R2
    run_once(1, 12, 0);   // R3 group code 11 -> channels 8-11
    run_once(1, 8, 0);    // R3
    run_once(1, 4, 0);    // R3
    run_once(2, 9, 0);    // R4
    read_all("R10");

    // Random one-shot runs
    for (int k = 0; k < 30; k++) run_once($urandom % 4, $urandom % 16, 0);
    read_all("R10");

    // R7 wrap in group 1, then R11 stop during a conversion
    cfg(1, 5, 1);
    req_cnt = 0;
    pulse_start();
    wait (req_cnt >= 6);
    @(negedge clk);
    start_clr = 1; abort_pend = 1;
    @(negedge clk); start_clr = 0;
    chk(busy == 0, "R11", busy, 0);
    repeat (10) @(negedge clk);
    chk(req_cnt == 6, "R11", req_cnt, 6);
    chk(scan_done == 0, "R11", scan_done, 0);
    chk(req_log[3] == 7 && req_log[4] == 4 && req_log[5] == 5, "R7", req_log[4], 4);
    @(negedge clk); rd_chan = 4'd5; #1;
    chk(rd_data == exp_mem[5], "R11", rd_data, exp_mem[5]);
    read_all("R10");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule